// File: doc/BRIEF.md
# ECC Error Capture Register Unit

This unit sits next to a DRAM ECC checker and keeps a record of memory error events so that software can examine them. The checker signals each correctable or uncorrectable error with a one-cycle pulse. Each kind of error has its own detail bus carrying the 4 KiB block address, an 8-bit syndrome and the channel that saw the error. The unit keeps a pending flag for each error kind and holds one set of captured details. These are the block address, the syndrome and the channel bit.

An uncorrectable error takes priority over the details of a pending correctable one. A correctable error never replaces details that are already held. Software reads the registers through a plain word-indexed port with a combinational read path and a single-cycle write. It clears pending flags by writing ones to them. A command register sets which flags drive the system-error output.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and `serrOut` is low.
- R2: A `ceValid` pulse with no flag pending sets status bit 0 and captures the error details. Offset 2 then reads `{ceBlkAddr, 12'h000}`, offset 3 reads the syndrome in bits 7:0, and offset 4 reads the channel in bit 0 with all upper bits zero.
- R3: A `ueValid` pulse with no uncorrectable flag pending sets status bit 7 and captures the uncorrectable details. This holds even if a correctable error is pending. When both pulses arrive in the same cycle, both flags set and the uncorrectable details are kept.
- R4: A correctable error that arrives while status bit 0 or bit 7 is set leaves the captured address, syndrome and channel unchanged. Which flag is set is judged by the value held before that cycle.
- R5: An uncorrectable error that arrives while status bit 7 is already set leaves the captured details unchanged.
- R6: A write to offset 0 clears status bit 0 or bit 7 where the written data has a one in that bit. A zero leaves the flag as it is. Clearing a flag does not change the captured details.
- R7: If a clear write and a new event of the same kind fall in the same cycle, the flag stays set.
- R8: The command register at offset 1 keeps only two bits: bit 7 enables the output for correctable errors and bit 8 enables it for uncorrectable errors. All other command bits read zero.
- R9: `serrOut` is high exactly while (status bit 0 AND command bit 7) OR (status bit 7 AND command bit 8) holds. It stays high until the matching flag is cleared or its enable is removed.
- R10: Status bits other than 0 and 7 read zero and ignore writes. Offsets 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceValid | input | 1 | Correctable error pulse |
| ceBlkAddr | input | 20 | Block address of the correctable error |
| ceSyndrome | input | 8 | Syndrome of the correctable error |
| ceChannel | input | 1 | Channel of the correctable error |
| ueValid | input | 1 | Uncorrectable error pulse |
| ueBlkAddr | input | 20 | Block address of the uncorrectable error |
| ueSyndrome | input | 8 | Syndrome of the uncorrectable error |
| ueChannel | input | 1 | Channel of the uncorrectable error |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| serrOut | output | 1 | System-error output |

## Verification
Each event pulse and each register write is sampled on a rising edge. The resulting flags, captured details and `serrOut` are therefore due one cycle later. Because reads are combinational, a read is due in the same cycle that `regAddr` is presented. The bench drives every stimulus a short delay after a rising edge and holds it across exactly one edge. It then sets `regAddr` and samples `regRdData` or `serrOut` a short delay after that edge, so every check looks at the first cycle in which the result is due.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;

  // Status bit positions (decoded by software)
  localparam int STS_CE_BIT = 0;
  localparam int STS_UE_BIT = 7;

  // Command enable bit positions
  localparam int CMD_CE_BIT = 7;
  localparam int CMD_UE_BIT = 8;

  // Register word indices
  localparam int REG_STATUS  = 0;
  localparam int REG_COMMAND = 1;
  localparam int REG_ADDR    = 2;
  localparam int REG_SYN     = 3;
  localparam int REG_CHAN    = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadDetail;  // capture error details this cycle
    logic selUe;       // pick the uncorrectable detail bus
    logic wrCmd;       // write the command enables
  } strobe_t;

endpackage

// File: rtl/ecc_err_log_ctrl.sv
module ecc_err_log_ctrl
  import ecc_err_log_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceValid,
  input  logic              ueValid,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              wrCeBit,
  input  logic              wrUeBit,
  output logic              ceFlag,
  output logic              ueFlag,
  output strobe_t           strobe
);

  logic wrStatus;
  logic clrCe;
  logic clrUe;
  logic ueTake;
  logic ceTake;

  assign wrStatus = regWrEn && (regAddr == REG_AW'(REG_STATUS));
  assign clrCe    = wrStatus && wrCeBit;
  assign clrUe    = wrStatus && wrUeBit;

  // An uncorrectable error takes the details unless one is already held;
  // a correctable error only takes them when nothing is pending.
  assign ueTake = ueValid && !ueFlag;
  assign ceTake = ceValid && !ceFlag && !ueFlag;

  always_comb begin
    strobe            = '0;
    strobe.loadDetail = ueTake || ceTake;
    strobe.selUe      = ueTake;
    strobe.wrCmd      = regWrEn && (regAddr == REG_AW'(REG_COMMAND));
  end

  // Event has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceFlag <= 1'b0;
      ueFlag <= 1'b0;
    end else begin
      ceFlag <= ceValid || (ceFlag && !clrCe);
      ueFlag <= ueValid || (ueFlag && !clrUe);
    end
  end

  AST_CE_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ceValid |=> ceFlag); // R7
  AST_UE_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ueValid |=> ueFlag); // R7
  AST_CE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrCe && !ceValid) |=> !ceFlag); // R6
  AST_UE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ueFlag && !clrUe) |=> ueFlag); // R6

endmodule

// File: rtl/ecc_err_log_dp.sv
module ecc_err_log_dp
  import ecc_err_log_pkg::*;
#(
  parameter int BLK_W  = 20,
  parameter int SYN_W  = 8,
  parameter int DATA_W = 32,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              ceValid,
  input  logic              ueValid,
  input  logic [BLK_W-1:0]  ceBlkAddr,
  input  logic [SYN_W-1:0]  ceSyndrome,
  input  logic              ceChannel,
  input  logic [BLK_W-1:0]  ueBlkAddr,
  input  logic [SYN_W-1:0]  ueSyndrome,
  input  logic              ueChannel,
  input  logic              ceFlag,
  input  logic              ueFlag,
  input  logic              wrCeEn,
  input  logic              wrUeEn,
  input  logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              serrOut
);

  localparam int OFS_W = DATA_W - BLK_W;  // always-zero low address bits

  logic [BLK_W-1:0] blkReg;
  logic [SYN_W-1:0] synReg;
  logic             chanReg;
  logic             cmdCe;
  logic             cmdUe;

  logic [BLK_W-1:0] blkNext;
  logic [SYN_W-1:0] synNext;
  logic             chanNext;

  assign blkNext  = strobe.selUe ? ueBlkAddr  : ceBlkAddr;
  assign synNext  = strobe.selUe ? ueSyndrome : ceSyndrome;
  assign chanNext = strobe.selUe ? ueChannel  : ceChannel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkReg  <= '0;
      synReg  <= '0;
      chanReg <= 1'b0;
    end else if (strobe.loadDetail) begin
      blkReg  <= blkNext;
      synReg  <= synNext;
      chanReg <= chanNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCe <= 1'b0;
      cmdUe <= 1'b0;
    end else if (strobe.wrCmd) begin
      cmdCe <= wrCeEn;
      cmdUe <= wrUeEn;
    end
  end

  assign serrOut = (ceFlag && cmdCe) || (ueFlag && cmdUe);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_AW'(REG_STATUS): begin
        regRdData[STS_CE_BIT] = ceFlag;
        regRdData[STS_UE_BIT] = ueFlag;
      end
      REG_AW'(REG_COMMAND): begin
        regRdData[CMD_CE_BIT] = cmdCe;
        regRdData[CMD_UE_BIT] = cmdUe;
      end
      REG_AW'(REG_ADDR): regRdData = {blkReg, {OFS_W{1'b0}}};
      REG_AW'(REG_SYN):  regRdData[SYN_W-1:0] = synReg;
      REG_AW'(REG_CHAN): regRdData[0] = chanReg;
      default: regRdData = '0;
    endcase
  end

  AST_UE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (ueValid && !ueFlag) |=> (blkReg == $past(ueBlkAddr) && synReg == $past(ueSyndrome))); // R3
  AST_CE_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (ceValid && !ueValid && (ceFlag || ueFlag)) |=> ($stable(blkReg) && $stable(synReg) && $stable(chanReg))); // R4
  AST_UE_KEEP_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (ueFlag && !ceValid && ueValid) |=> ($stable(blkReg) && $stable(synReg))); // R5

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_log_pkg::*;
#(
  parameter int BLK_W  = 20,
  parameter int SYN_W  = 8,
  parameter int DATA_W = 32,
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceValid,
  input  logic [BLK_W-1:0]  ceBlkAddr,
  input  logic [SYN_W-1:0]  ceSyndrome,
  input  logic              ceChannel,
  input  logic              ueValid,
  input  logic [BLK_W-1:0]  ueBlkAddr,
  input  logic [SYN_W-1:0]  ueSyndrome,
  input  logic              ueChannel,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              serrOut
);

  strobe_t strobe;
  logic    ceFlag;
  logic    ueFlag;
  logic    unusedWrBits;

  assign unusedWrBits = ^regWrData;

  ecc_err_log_ctrl #(
    .REG_AW (REG_AW)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ceValid (ceValid),
    .ueValid (ueValid),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .wrCeBit (regWrData[STS_CE_BIT]),
    .wrUeBit (regWrData[STS_UE_BIT]),
    .ceFlag  (ceFlag),
    .ueFlag  (ueFlag),
    .strobe  (strobe)
  );

  ecc_err_log_dp #(
    .BLK_W  (BLK_W),
    .SYN_W  (SYN_W),
    .DATA_W (DATA_W),
    .REG_AW (REG_AW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ceValid    (ceValid),
    .ueValid    (ueValid),
    .ceBlkAddr  (ceBlkAddr),
    .ceSyndrome (ceSyndrome),
    .ceChannel  (ceChannel),
    .ueBlkAddr  (ueBlkAddr),
    .ueSyndrome (ueSyndrome),
    .ueChannel  (ueChannel),
    .ceFlag     (ceFlag),
    .ueFlag     (ueFlag),
    .wrCeEn     (regWrData[CMD_CE_BIT]),
    .wrUeEn     (regWrData[CMD_UE_BIT]),
    .regAddr    (regAddr),
    .regRdData  (regRdData),
    .serrOut    (serrOut)
  );

  AST_SERR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    serrOut |-> (ceFlag || ueFlag)); // R9
  AST_SERR_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (!ceValid && !ueValid && !ueFlag && ceFlag && regWrEn &&
     regAddr == REG_AW'(REG_STATUS) && regWrData[STS_CE_BIT]) |=> !serrOut); // R9

endmodule

// File: tb/test_ecc_err_log.sv
`timescale 1ns/100ps
module test_ecc_err_log;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceValid = 1'b0;
  logic [19:0] ceBlkAddr = '0;
  logic [7:0]  ceSyndrome = '0;
  logic        ceChannel = 1'b0;
  logic        ueValid = 1'b0;
  logic [19:0] ueBlkAddr = '0;
  logic [7:0]  ueSyndrome = '0;
  logic        ueChannel = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        serrOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk(clk), .rstN(rstN),
    .ceValid(ceValid), .ceBlkAddr(ceBlkAddr), .ceSyndrome(ceSyndrome), .ceChannel(ceChannel),
    .ueValid(ueValid), .ueBlkAddr(ueBlkAddr), .ueSyndrome(ueSyndrome), .ueChannel(ueChannel),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .serrOut(serrOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic checkReg(input string req, input logic [2:0] a, input logic [31:0] exp);
    regAddr = a;
    #0.5;
    check(req, regRdData, exp);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic setCe(input logic [19:0] a, input logic [7:0] s, input logic c);
    ceValid = 1'b1; ceBlkAddr = a; ceSyndrome = s; ceChannel = c;
  endtask

  task automatic setUe(input logic [19:0] a, input logic [7:0] s, input logic c);
    ueValid = 1'b1; ueBlkAddr = a; ueSyndrome = s; ueChannel = c;
  endtask

  task automatic dropEvents();
    ceValid = 1'b0; ueValid = 1'b0;
  endtask

  task automatic testReset();
    checkReg("R1 status", 3'd0, 32'h0);
    checkReg("R1 command", 3'd1, 32'h0);
    checkReg("R1 address", 3'd2, 32'h0);
    checkReg("R1 syndrome", 3'd3, 32'h0);
    checkReg("R1 channel", 3'd4, 32'h0);
    check("R1 serr", {31'b0, serrOut}, 32'h0);
  endtask

  task automatic testCeCapture();
    setCe(20'hABCDE, 8'h5A, 1'b1); tick(); dropEvents();
    checkReg("R2 status", 3'd0, 32'h1);
    checkReg("R2 address", 3'd2, 32'hABCDE000);
    checkReg("R2 syndrome", 3'd3, 32'h5A);
    checkReg("R2 channel", 3'd4, 32'h1);
    check("R9 serr disabled", {31'b0, serrOut}, 32'h0);
  endtask

  task automatic testCeBlocked();
    setCe(20'h11111, 8'h22, 1'b0); tick(); dropEvents();
    checkReg("R4 status", 3'd0, 32'h1);
    checkReg("R4 address", 3'd2, 32'hABCDE000);
    checkReg("R4 syndrome", 3'd3, 32'h5A);
    checkReg("R4 channel", 3'd4, 32'h1);
  endtask

  task automatic testUeOverCe();
    setUe(20'h12345, 8'hC3, 1'b0); tick(); dropEvents();
    checkReg("R3 status", 3'd0, 32'h81);
    checkReg("R3 address", 3'd2, 32'h12345000);
    checkReg("R3 syndrome", 3'd3, 32'hC3);
    checkReg("R3 channel", 3'd4, 32'h0);
  endtask

  task automatic testUeTwice();
    setUe(20'h0F0F0, 8'h99, 1'b1); tick(); dropEvents();
    checkReg("R5 address", 3'd2, 32'h12345000);
    checkReg("R5 syndrome", 3'd3, 32'hC3);
    setCe(20'h55555, 8'h66, 1'b1); tick(); dropEvents();
    checkReg("R4 address under UE", 3'd2, 32'h12345000);
    checkReg("R4 channel under UE", 3'd4, 32'h0);
  endtask

  task automatic testW1c();
    writeReg(3'd0, 32'h1);
    checkReg("R6 clear CE", 3'd0, 32'h80);
    checkReg("R6 details kept", 3'd2, 32'h12345000);
    writeReg(3'd0, 32'h0);
    checkReg("R6 zero keeps", 3'd0, 32'h80);
    writeReg(3'd0, 32'h80);
    checkReg("R6 clear UE", 3'd0, 32'h0);
    writeReg(3'd0, 32'hFFFF_FF7E);
    checkReg("R10 reserved status", 3'd0, 32'h0);
  endtask

  task automatic testSameCycle();
    setCe(20'h00001, 8'h01, 1'b0); tick(); dropEvents();
    checkReg("R2 recapture", 3'd2, 32'h00001000);
    setCe(20'h77777, 8'h77, 1'b1);
    regWrEn = 1'b1; regAddr = 3'd0; regWrData = 32'h81;
    tick();
    dropEvents(); regWrEn = 1'b0; regWrData = '0;
    checkReg("R7 flag stays", 3'd0, 32'h1);
    checkReg("R7 details kept", 3'd2, 32'h00001000);
    writeReg(3'd0, 32'h81);
    checkReg("R6 cleared", 3'd0, 32'h0);
  endtask

  task automatic testBoth();
    setCe(20'h33333, 8'h10, 1'b1);
    setUe(20'h44444, 8'h20, 1'b0);
    tick(); dropEvents();
    checkReg("R3 both status", 3'd0, 32'h81);
    checkReg("R3 both address", 3'd2, 32'h44444000);
    checkReg("R3 both syndrome", 3'd3, 32'h20);
    checkReg("R3 both channel", 3'd4, 32'h0);
    writeReg(3'd0, 32'h81);
  endtask

  task automatic testCmdIrq();
    writeReg(3'd1, 32'hFFFF_FFFF);
    checkReg("R8 command bits", 3'd1, 32'h180);
    writeReg(3'd1, 32'h80);
    checkReg("R8 command CE only", 3'd1, 32'h80);
    setUe(20'h00002, 8'h02, 1'b0); tick(); dropEvents();
    check("R9 UE disabled", {31'b0, serrOut}, 32'h0);
    setCe(20'h00003, 8'h03, 1'b0); tick(); dropEvents();
    check("R9 CE enabled", {31'b0, serrOut}, 32'h1);
    tick();
    check("R9 stays high", {31'b0, serrOut}, 32'h1);
    writeReg(3'd0, 32'h1);
    check("R9 CE cleared", {31'b0, serrOut}, 32'h0);
    writeReg(3'd1, 32'h100);
    check("R9 UE enabled", {31'b0, serrOut}, 32'h1);
    writeReg(3'd0, 32'h80);
    check("R9 UE cleared", {31'b0, serrOut}, 32'h0);
  endtask

  task automatic testUnusedOffsets();
    writeReg(3'd5, 32'hFFFF_FFFF);
    checkReg("R10 offset5", 3'd5, 32'h0);
    checkReg("R10 offset6", 3'd6, 32'h0);
    checkReg("R10 offset7", 3'd7, 32'h0);
    checkReg("R10 status untouched", 3'd0, 32'h0);
  endtask

  initial begin
    #1;
    testReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    testReset();
    testCeCapture();
    testCeBlocked();
    testUeOverCe();
    testUeTwice();
    testW1c();
    testSameCycle();
    testBoth();
    testCmdIrq();
    testUnusedOffsets();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule